// File: doc/BRIEF.md
# Shift-Register Return-Address Stack

This block keeps the return addresses of nested subroutine calls for a processor core. It holds them in a short chain of registers and has no addressed memory and no pointer. On a call, the return address supplied by the fetch logic drops into the top register, and every older entry moves one level deeper in the same clock edge. On a return, the top entry is handed back at once as the program counter to resume from, and at the next edge every entry moves one level toward the top.

Each register chooses between two sources: its neighbour above on a push, or its neighbour below on a pop. A call or return therefore costs no cycle beyond the instruction that issues it. A saturating occupancy count drives the empty and full indications, and these do not affect the shifting. The chain is built so that a call on a full stack silently drops its deepest entry. A parameter chooses what refills the deepest level on a return: zero, or a copy of its own value.

Top module: `ras_shift_stack`

## Requirements
- R1: When call_i is high at a rising edge, top_o equals the ret_addr_i of that cycle after that edge, and every deeper level holds what the level above it held before the edge.
- R2: While ret_i is high and call_i is low, pc_ret_o shows the current top entry in that same cycle. In every other cycle pc_ret_o is zero. At the edge that ends a return cycle, every level loads the value of the level below it.
- R3: Calls and returns may arrive on consecutive cycles, and each one takes effect at the very next edge. A cycle with neither signal high leaves every level unchanged.
- R4: A call while full_o is high discards the deepest entry, raises no flag, and keeps full_o high.
- R5: On a return, the deepest level loads zero when FILL_ZERO is 1 (the default) and keeps its own value when FILL_ZERO is 0.
- R6: When call_i and ret_i are both high, the cycle acts as a call only, and pc_ret_o stays zero.
- R7: The occupancy goes up by one on a call and down by one on a return, and stays within 0 and DEPTH. empty_o is high at 0 and full_o is high at DEPTH. A return on an empty stack still shifts the levels and leaves empty_o high.
- R8: While rst_n is low, every level and the occupancy are cleared. After reset, top_o is zero, empty_o is 1 and full_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Push the return address this cycle |
| ret_i | input | 1 | Pop the top entry this cycle |
| ret_addr_i | input | AW | Return address to capture on a call |
| pc_ret_o | output | AW | Program counter to resume from during a return, otherwise zero |
| top_o | output | AW | Current top entry |
| empty_o | output | 1 | Occupancy is zero |
| full_o | output | 1 | Occupancy equals DEPTH |

## Verification
pc_ret_o is combinational, so it is due in the cycle the return is driven. The bench samples it one nanosecond after the input change, which is before the next rising edge. top_o, empty_o and full_o all pass through one register, so they are due just after the edge that ends the stimulus cycle. The driver queues the values it expects for those outputs, and the monitor compares them one nanosecond after that edge. Two instances run on the same inputs, one at the default depth that fills with zero and one three levels deep that holds its value. Deeper entries are observed by popping them out through pc_ret_o.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } ras_op_e;

  // Call outranks return when both are raised together.
  function automatic ras_op_e decode_op(input logic call, input logic ret);
    if (call)     return OP_PUSH;
    else if (ret) return OP_POP;
    else          return OP_IDLE;
  endfunction

  // Saturating occupancy arithmetic, bounded by 0 and depth.
  function automatic int occ_next(input int cnt, input ras_op_e op, input int depth);
    int n;
    n = cnt;
    if (op == OP_PUSH && cnt < depth) n = cnt + 1;
    if (op == OP_POP  && cnt > 0)     n = cnt - 1;
    return n;
  endfunction

endpackage

// File: rtl/ras_cell.sv
module ras_cell #(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ras_pkg::ras_op_e op_i,
  input  logic [AW-1:0]    upper_i,
  input  logic [AW-1:0]    lower_i,
  output logic [AW-1:0]    q_o
);
  import ras_pkg::*;

  logic [AW-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q_r <= '0;
    else if (op_i == OP_PUSH) q_r <= upper_i;
    else if (op_i == OP_POP)  q_r <= lower_i;
  end

  assign q_o = q_r;

  AST_PUSH_FROM_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH) |=> (q_o == $past(upper_i))); // R1
  AST_POP_FROM_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_POP) |=> (q_o == $past(lower_i))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_IDLE) |=> $stable(q_o)); // R3

endmodule

// File: rtl/ras_occupancy.sv
module ras_occupancy #(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ras_pkg::ras_op_e op_i,
  output logic             empty_o,
  output logic             full_o
);
  import ras_pkg::*;

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= CW'(occ_next(int'(count_q), op_i, DEPTH));
  end

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count_q) <= DEPTH)); // R7
  AST_OCC_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH && !full_o) |=> (int'(count_q) == int'($past(count_q)) + 1)); // R7
  AST_OCC_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_POP && !empty_o) |=> (int'(count_q) == int'($past(count_q)) - 1)); // R7
  AST_EMPTY_POP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_POP && empty_o) |=> empty_o); // R7
  AST_FULL_PUSH_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH && full_o) |=> full_o); // R4

endmodule

// File: rtl/ras_shift_stack.sv
module ras_shift_stack #(
  parameter int   AW        = 16,
  parameter int   DEPTH     = 2,
  parameter logic FILL_ZERO = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [AW-1:0] ret_addr_i,
  output logic [AW-1:0] pc_ret_o,
  output logic [AW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o
);
  import ras_pkg::*;

  ras_op_e       op;
  logic          push_evt;
  logic          pop_evt;
  logic [AW-1:0] stage_q   [DEPTH];
  logic [AW-1:0] stage_up  [DEPTH];
  logic [AW-1:0] stage_low [DEPTH];

  assign op       = decode_op(call_i, ret_i);
  assign push_evt = (op == OP_PUSH);
  assign pop_evt  = (op == OP_POP);

  for (genvar i = 0; i < DEPTH; i++) begin : g_level
    if (i == 0) begin : g_head
      assign stage_up[i] = ret_addr_i;
    end else begin : g_body
      assign stage_up[i] = stage_q[i-1];
    end

    if (i == DEPTH - 1) begin : g_tail
      if (FILL_ZERO) begin : g_zero
        assign stage_low[i] = '0;
      end else begin : g_hold
        assign stage_low[i] = stage_q[i];
      end
    end else begin : g_link
      assign stage_low[i] = stage_q[i+1];
    end

    ras_cell #(.AW(AW)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (op),
      .upper_i (stage_up[i]),
      .lower_i (stage_low[i]),
      .q_o     (stage_q[i])
    );
  end

  ras_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .empty_o (empty_o),
    .full_o  (full_o)
  );

  assign top_o    = stage_q[0];
  assign pc_ret_o = pop_evt ? stage_q[0] : '0;

  AST_CALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> (top_o == $past(ret_addr_i))); // R1
  AST_RET_PRESENTS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i) |-> (pc_ret_o == top_o)); // R2
  AST_CALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |-> (pc_ret_o == '0)); // R6
  AST_NO_RET_NO_PC: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_i |-> (pc_ret_o == '0)); // R2
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o)); // R7

  if (DEPTH > 1) begin : g_deep_chk
    AST_OVERFLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_evt && full_o) |=> (stage_q[DEPTH-1] == $past(stage_q[DEPTH-2]))); // R4
  end

  if (FILL_ZERO) begin : g_fill_chk
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pop_evt |=> (stage_q[DEPTH-1] == '0)); // R5
  end else begin : g_hold_chk
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pop_evt |=> $stable(stage_q[DEPTH-1])); // R5
  end

endmodule

// File: tb/ras_shift_stack_bench.sv
module ras_shift_stack_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_i = 1'b0;
  logic          ret_i = 1'b0;
  logic [AW-1:0] addr_i = '0;

  logic [AW-1:0] pc_a, top_a, pc_b, top_b;
  logic          emp_a, ful_a, emp_b, ful_b;

  always #2 clk = ~clk;

  ras_shift_stack #(.AW(AW), .DEPTH(2), .FILL_ZERO(1'b1)) u_ras_shift_stack (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .ret_addr_i(addr_i),
    .pc_ret_o(pc_a), .top_o(top_a), .empty_o(emp_a), .full_o(ful_a));

  ras_shift_stack #(.AW(AW), .DEPTH(3), .FILL_ZERO(1'b0)) u_hold (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .ret_addr_i(addr_i),
    .pc_ret_o(pc_b), .top_o(top_b), .empty_o(emp_b), .full_o(ful_b));

  // Reference models: [unit][level]
  int            dep [2] = '{2, 3};
  bit            fz  [2] = '{1'b1, 1'b0};
  logic [AW-1:0] mdl [2][4];
  int            cnt [2];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [AW-1:0] q_top [$];
  logic          q_emp [$];
  logic          q_ful [$];
  int            q_dut [$];
  string         q_tag [$];

  task automatic check(input string tag, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int u = 0; u < 2; u++) begin
      cnt[u] = 0;
      for (int l = 0; l < 4; l++) mdl[u][l] = '0;
    end
  endtask

  // Driver: applies one cycle of stimulus, checks the same-cycle output,
  // and queues the post-edge expectations for the monitor.
  task automatic do_op(input logic c, input logic r, input logic [AW-1:0] a, input string tag);
    logic [AW-1:0] exp_pc;
    @(negedge clk);
    call_i = c; ret_i = r; addr_i = a;
    #1;
    for (int u = 0; u < 2; u++) begin
      exp_pc = (r && !c) ? mdl[u][0] : '0;
      check(tag, (u == 0) ? "pc_ret A" : "pc_ret B", (u == 0) ? pc_a : pc_b, exp_pc);
    end
    for (int u = 0; u < 2; u++) begin
      if (c) begin
        for (int l = dep[u] - 1; l > 0; l--) mdl[u][l] = mdl[u][l-1];
        mdl[u][0] = a;
        if (cnt[u] < dep[u]) cnt[u]++;
      end else if (r) begin
        for (int l = 0; l < dep[u] - 1; l++) mdl[u][l] = mdl[u][l+1];
        if (fz[u]) mdl[u][dep[u]-1] = '0;
        if (cnt[u] > 0) cnt[u]--;
      end
      q_top.push_back(mdl[u][0]);
      q_emp.push_back(cnt[u] == 0);
      q_ful.push_back(cnt[u] == dep[u]);
      q_dut.push_back(u);
      q_tag.push_back(tag);
    end
  endtask

  // Monitor: compares registered outputs just after the edge.
  always @(posedge clk) begin
    #1;
    while (q_dut.size() > 0) begin
      int            u;
      logic [AW-1:0] et;
      logic          ee, ef;
      string         tg;
      u  = q_dut.pop_front();
      et = q_top.pop_front();
      ee = q_emp.pop_front();
      ef = q_ful.pop_front();
      tg = q_tag.pop_front();
      check(tg, "top", (u == 0) ? top_a : top_b, et);
      check(tg, "empty", AW'((u == 0) ? emp_a : emp_b), AW'(ee));
      check(tg, "full", AW'((u == 0) ? ful_a : ful_b), AW'(ef));
    end
  end

  task automatic check_reset(input string tag);
    check(tag, "top A", top_a, '0);
    check(tag, "top B", top_b, '0);
    check(tag, "empty A", AW'(emp_a), AW'(1));
    check(tag, "empty B", AW'(emp_b), AW'(1));
    check(tag, "full A", AW'(ful_a), AW'(0));
    check(tag, "pc A", pc_a, '0);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_reset("R8 after reset");

    do_op(1'b1, 1'b0, 16'h1111, "R1 first call");
    do_op(1'b1, 1'b0, 16'h2222, "R1 second call");
    do_op(1'b1, 1'b0, 16'h3333, "R4 call on full");
    do_op(1'b1, 1'b0, 16'h4444, "R4 overflow drop");
    do_op(1'b0, 1'b1, 16'hffff, "R2 return top");
    do_op(1'b0, 1'b1, 16'h0000, "R2 return next");
    do_op(1'b0, 1'b1, 16'h0000, "R5 tail fill");
    do_op(1'b0, 1'b1, 16'h0000, "R7 pop on empty");
    do_op(1'b0, 1'b0, 16'hbeef, "R3 idle hold");
    do_op(1'b1, 1'b1, 16'h5555, "R6 call and return");
    do_op(1'b0, 1'b1, 16'h0000, "R6 follow-up return");
    do_op(1'b1, 1'b0, 16'h6666, "R3 back to back call");
    do_op(1'b0, 1'b1, 16'h0000, "R3 back to back return");
    do_op(1'b1, 1'b0, 16'h7777, "R3 alternate call");
    do_op(1'b1, 1'b0, 16'h8888, "R3 alternate call 2");
    do_op(1'b0, 1'b0, 16'h0000, "R3 idle after calls");
    do_op(1'b0, 1'b1, 16'h0000, "R2 drain");
    do_op(1'b0, 1'b1, 16'h0000, "R5 drain tail");
    do_op(1'b0, 1'b1, 16'h0000, "R5 drain tail 2");
    do_op(1'b1, 1'b0, 16'h9999, "R1 refill");
    do_op(1'b1, 1'b0, 16'haaaa, "R7 refill full");
    do_op(1'b0, 1'b0, 16'h0000, "R3 settle");

    @(negedge clk);
    rst_n = 1'b0;
    call_i = 1'b0; ret_i = 1'b0; addr_i = '0;
    model_clear();
    @(negedge clk);
    #1;
    check_reset("R8 reset mid run");
    rst_n = 1'b1;
    do_op(1'b0, 1'b1, 16'h0000, "R8 pop after reset");
    do_op(1'b0, 1'b0, 16'h0000, "R8 quiet");
    repeat (2) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule